// File: doc/BRIEF.md
# Shadow Return Address Checker

This block follows a stream of retired control-flow events from a processor core and keeps its own private stack of return addresses next to the ordinary program stack. When a call retires, the core reports the return address. The block pushes it onto the shadow stack that is currently active, while the ordinary stack receives its copy in memory. When a return retires, the core reports the address it took from the ordinary stack. The block pops its own copy and compares the two. If they differ, the block raises a control-protection fault and does not flag the return as valid.

There are eight shadow stacks: stack 0 serves normal execution and stacks 1 to 7 serve interrupt levels. Each stack has its own banked entry pointer. An interrupt event names one of the seven alternate stacks, and a matching interrupt-return restores the selection that was active before. Up to two interrupt levels can nest. The storage has no load or store path. Ordinary memory accesses that reach the block are refused and cannot change it.

Top module: `shadow_ret_guard`

## Requirements
- R1: A synchronous reset, with `rst_i` high at a clock edge, empties all eight stacks and the selection nesting, sets `active_stack_o` to 0, and holds every output pulse low.
- R2: A call event (kind code 0) with no fault pushes `evt_addr_i` onto the active stack. Returns then see the pushed addresses in last-in, first-out order. A call never changes `active_stack_o`.
- R3: A return event (kind code 1) on a non-empty stack always pops one entry. If the entry equals `evt_addr_i`, `ret_ok_o` pulses. If it does not, `fault_o` pulses with cause 0 (mismatch) and `ret_ok_o` stays low. `ret_ok_o` and `fault_o` are never high together.
- R4: A call on a stack that already holds DEPTH entries (16 by default) raises a fault with cause 1 (overflow) and stores nothing. The 16 entries already held are unchanged.
- R5: A return on an empty active stack raises a fault with cause 2 (underflow). No `ret_ok_o` pulse is given.
- R6: A load event (kind code 4) or a store event (kind code 5) gives an `access_deny_o` pulse. It changes no stack entry, no pointer and no selection.
- R7: An interrupt event (kind code 2) with a level from 1 to 7 on `evt_level_i` makes that stack active. Each stack keeps its own entries and pointer, independently of the others.
- R8: An interrupt-return event (kind code 3) restores the selection that was active before the matching interrupt, with two levels of nesting.
- R9: An interrupt event while two levels are already nested raises a fault with cause 1 and leaves the selection unchanged. An interrupt-return with no nesting raises a fault with cause 2 and leaves the selection unchanged.
- R10: An interrupt event with level 0 is ignored. It raises no fault and leaves the selection unchanged.
- R11: The outputs `fault_o`, `fault_cause_o`, `ret_ok_o` and `access_deny_o` are registered. Each reflects the event of the previous clock edge and lasts one cycle. They stay low in a cycle after `evt_valid_i` was low, and also after the unused kind codes 6 and 7. The cause code is 0 when no fault is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| evt_valid_i | input | 1 | An event is presented in this cycle |
| evt_kind_i | input | 3 | Event kind: 0 call, 1 return, 2 interrupt, 3 interrupt-return, 4 load, 5 store |
| evt_addr_i | input | ADDR_W | Return address pushed on a call, or the ordinary-stack address on a return |
| evt_level_i | input | SEL_W | Alternate stack index, 1 to 7, carried by an interrupt event |
| ret_ok_o | output | 1 | One-cycle pulse for a return whose addresses matched |
| fault_o | output | 1 | One-cycle control-protection fault pulse |
| fault_cause_o | output | 2 | Fault cause: 0 mismatch, 1 overflow, 2 underflow |
| access_deny_o | output | 1 | One-cycle pulse that refuses a load or store |
| active_stack_o | output | SEL_W | Index of the active shadow stack, 0 for normal execution |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 16 entries per stack, seven alternate stacks and two nesting levels. With 16 entries, a directed sequence can fill a stack to the limit and drain it again in a few dozen events. With two nesting levels, the random mix of interrupt and interrupt-return events runs into the nesting limit and the empty-nesting case often. With eight stacks at 3-bit selection, every level code has a stack, so level 0 is the only ignored value. The random phase steers three quarters of the returns onto the correct address, so that matches, mismatches, underflows and overflows all occur on several stacks.

// File: rtl/srs_pkg.sv
package srs_pkg;

   typedef enum logic [2:0] {
      EV_CALL  = 3'd0,
      EV_RET   = 3'd1,
      EV_INT   = 3'd2,
      EV_IRET  = 3'd3,
      EV_LOAD  = 3'd4,
      EV_STORE = 3'd5
   } ev_kind_e;

   typedef enum logic [1:0] {
      FC_MISMATCH  = 2'd0,
      FC_OVERFLOW  = 2'd1,
      FC_UNDERFLOW = 2'd2
   } fault_cause_e;

   typedef struct packed {
      logic         hit;
      fault_cause_e cause;
   } fault_t;

endpackage

// File: rtl/srs_stack_bank.sv
// Banked return-address storage: one entry counter per stack, a shared array,
// and a read/write port steered by the current selection.
module srs_stack_bank #(
   parameter int ADDR_W  = 32,
   parameter int DEPTH   = 16,
   parameter int NUM_STK = 8,
   parameter int SEL_W   = 3
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic [ADDR_W-1:0] wdata_i,
   output logic [ADDR_W-1:0] top_o,
   output logic              full_o,
   output logic              empty_o
);

   localparam int PTR_W = $clog2(DEPTH + 1);
   localparam int IDX_W = $clog2(DEPTH);

   if (DEPTH < 2 || DEPTH != (1 << IDX_W)) begin : g_bad_depth
      $error("srs_stack_bank: DEPTH must be a power of two and at least 2");
   end
   if (NUM_STK != (1 << SEL_W)) begin : g_bad_stk
      $error("srs_stack_bank: NUM_STK must equal 2**SEL_W");
   end

   logic [PTR_W-1:0]  cnt_w [NUM_STK];
   logic [ADDR_W-1:0] mem_q [NUM_STK][DEPTH];
   logic [PTR_W-1:0]  cur_cnt;
   logic [IDX_W-1:0]  wr_idx;
   logic [IDX_W-1:0]  rd_idx;

   // one banked pointer per stack; only the selected one moves
   for (genvar s = 0; s < NUM_STK; s++) begin : g_ptr
      logic [PTR_W-1:0] cnt_q;
      logic             is_sel;
      assign is_sel = (sel_i == SEL_W'(s));
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            cnt_q <= '0;
         end else if (push_i && is_sel) begin
            cnt_q <= cnt_q + PTR_W'(1);
         end else if (pop_i && is_sel) begin
            cnt_q <= cnt_q - PTR_W'(1);
         end
      end
      assign cnt_w[s] = cnt_q;
   end

   always_comb begin
      cur_cnt = cnt_w[sel_i];
      wr_idx  = cur_cnt[IDX_W-1:0];
      rd_idx  = IDX_W'(cur_cnt - PTR_W'(1));
      full_o  = (cur_cnt == PTR_W'(DEPTH));
      empty_o = (cur_cnt == '0);
      top_o   = mem_q[sel_i][rd_idx];
   end

   always_ff @(posedge clk_i) begin
      if (push_i) begin
         mem_q[sel_i][wr_idx] <= wdata_i;
      end
   end

endmodule

// File: rtl/srs_sel_stack.sv
// Small nesting stack of saved stack selections (shift-register form).
module srs_sel_stack #(
   parameter int SEL_W = 3,
   parameter int NEST  = 2
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic [SEL_W-1:0] val_i,
   output logic [SEL_W-1:0] top_o,
   output logic             full_o,
   output logic             empty_o
);

   localparam int CNT_W = $clog2(NEST + 1);

   if (NEST < 1) begin : g_bad_nest
      $error("srs_sel_stack: NEST must be at least 1");
   end

   logic [SEL_W-1:0] slot_w [NEST];
   logic [CNT_W-1:0] cnt_q;

   for (genvar i = 0; i < NEST; i++) begin : g_slot
      logic [SEL_W-1:0] slot_q;
      logic [SEL_W-1:0] push_val;
      logic [SEL_W-1:0] pop_val;
      if (i == 0) begin : g_head
         assign push_val = val_i;
      end else begin : g_body
         assign push_val = slot_w[i-1];
      end
      if (i == NEST - 1) begin : g_tail
         assign pop_val = '0;
      end else begin : g_inner
         assign pop_val = slot_w[i+1];
      end
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            slot_q <= '0;
         end else if (push_i) begin
            slot_q <= push_val;
         end else if (pop_i) begin
            slot_q <= pop_val;
         end
      end
      assign slot_w[i] = slot_q;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= '0;
      end else if (push_i) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end else if (pop_i) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign top_o   = slot_w[0];
   assign full_o  = (cnt_q == CNT_W'(NEST));
   assign empty_o = (cnt_q == '0);

endmodule

// File: rtl/shadow_ret_guard.sv
module shadow_ret_guard
   import srs_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DEPTH   = 16,
   parameter int NUM_ALT = 7,
   parameter int NEST    = 2,
   localparam int NUM_STK = NUM_ALT + 1,
   localparam int SEL_W   = $clog2(NUM_STK)
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              evt_valid_i,
   input  logic [2:0]        evt_kind_i,
   input  logic [ADDR_W-1:0] evt_addr_i,
   input  logic [SEL_W-1:0]  evt_level_i,
   output logic              ret_ok_o,
   output logic              fault_o,
   output logic [1:0]        fault_cause_o,
   output logic              access_deny_o,
   output logic [SEL_W-1:0]  active_stack_o
);

   if (ADDR_W < 1) begin : g_bad_addr
      $error("shadow_ret_guard: ADDR_W must be positive");
   end
   if (NUM_ALT < 1) begin : g_bad_alt
      $error("shadow_ret_guard: NUM_ALT must be at least 1");
   end

   logic              is_call, is_ret, is_int, is_iret, is_mem;
   logic              push, pop, mismatch;
   logic              int_ok, int_ovf, iret_ok, iret_unf;
   logic [ADDR_W-1:0] top_addr;
   logic              stk_full, stk_empty;
   logic [SEL_W-1:0]  sel_q, sel_top;
   logic              nest_full, nest_empty;
   fault_t            fnext;

   // event decode
   always_comb begin
      is_call = evt_valid_i && (evt_kind_i == EV_CALL);
      is_ret  = evt_valid_i && (evt_kind_i == EV_RET);
      is_int  = evt_valid_i && (evt_kind_i == EV_INT);
      is_iret = evt_valid_i && (evt_kind_i == EV_IRET);
      is_mem  = evt_valid_i && ((evt_kind_i == EV_LOAD) || (evt_kind_i == EV_STORE));
   end

   assign push     = is_call && !stk_full;
   assign pop      = is_ret && !stk_empty;
   assign mismatch = pop && (top_addr != evt_addr_i);
   assign int_ok   = is_int && (evt_level_i != '0) && !nest_full;
   assign int_ovf  = is_int && (evt_level_i != '0) && nest_full;
   assign iret_ok  = is_iret && !nest_empty;
   assign iret_unf = is_iret && nest_empty;

   srs_stack_bank #(
      .ADDR_W  (ADDR_W),
      .DEPTH   (DEPTH),
      .NUM_STK (NUM_STK),
      .SEL_W   (SEL_W)
   ) u_bank (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .sel_i   (sel_q),
      .push_i  (push),
      .pop_i   (pop),
      .wdata_i (evt_addr_i),
      .top_o   (top_addr),
      .full_o  (stk_full),
      .empty_o (stk_empty)
   );

   srs_sel_stack #(
      .SEL_W (SEL_W),
      .NEST  (NEST)
   ) u_nest (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .push_i  (int_ok),
      .pop_i   (iret_ok),
      .val_i   (sel_q),
      .top_o   (sel_top),
      .full_o  (nest_full),
      .empty_o (nest_empty)
   );

   // fault classification; overflow and underflow take priority over compare
   always_comb begin
      fnext.hit   = 1'b0;
      fnext.cause = FC_MISMATCH;
      if ((is_call && stk_full) || int_ovf) begin
         fnext.hit   = 1'b1;
         fnext.cause = FC_OVERFLOW;
      end else if ((is_ret && stk_empty) || iret_unf) begin
         fnext.hit   = 1'b1;
         fnext.cause = FC_UNDERFLOW;
      end else if (mismatch) begin
         fnext.hit   = 1'b1;
         fnext.cause = FC_MISMATCH;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sel_q         <= '0;
         fault_o       <= 1'b0;
         fault_cause_o <= 2'd0;
         ret_ok_o      <= 1'b0;
         access_deny_o <= 1'b0;
      end else begin
         if (int_ok) begin
            sel_q <= evt_level_i;
         end else if (iret_ok) begin
            sel_q <= sel_top;
         end
         fault_o       <= fnext.hit;
         fault_cause_o <= fnext.cause;
         ret_ok_o      <= pop && !mismatch;
         access_deny_o <= is_mem;
      end
   end

   assign active_stack_o = sel_q;

endmodule

// File: rtl/srs_guard_chk.sv
module srs_guard_chk #(
   parameter int SEL_W = 3,
   parameter int NEST  = 2
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             evt_valid_i,
   input logic [2:0]       evt_kind_i,
   input logic [SEL_W-1:0] evt_level_i,
   input logic             ret_ok_o,
   input logic             fault_o,
   input logic [1:0]       fault_cause_o,
   input logic             access_deny_o,
   input logic [SEL_W-1:0] active_stack_o
);

   int unsigned nest_cnt;
   logic        ev_int, ev_iret, ev_mem, ev_call;

   assign ev_call = evt_valid_i && (evt_kind_i == 3'd0);
   assign ev_int  = evt_valid_i && (evt_kind_i == 3'd2);
   assign ev_iret = evt_valid_i && (evt_kind_i == 3'd3);
   assign ev_mem  = evt_valid_i && ((evt_kind_i == 3'd4) || (evt_kind_i == 3'd5));

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         nest_cnt <= 0;
      end else if (ev_int && (evt_level_i != '0) && (nest_cnt < NEST)) begin
         nest_cnt <= nest_cnt + 1;
      end else if (ev_iret && (nest_cnt != 0)) begin
         nest_cnt <= nest_cnt - 1;
      end
   end

   p_reset_clear_r1: assert property (@(posedge clk_i)
      rst_i |=> !fault_o && !ret_ok_o && !access_deny_o && (active_stack_o == '0));

   p_call_keeps_sel_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      ev_call |=> $stable(active_stack_o) && !ret_ok_o);

   p_ok_fault_excl_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      !(ret_ok_o && fault_o));

   p_deny_mem_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      ev_mem |=> access_deny_o && !fault_o && $stable(active_stack_o));

   p_int_switch_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (ev_int && (evt_level_i != '0) && (nest_cnt < NEST)) |=>
         (active_stack_o == $past(evt_level_i)) && !fault_o);

   p_int_nest_ovf_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (ev_int && (evt_level_i != '0) && (nest_cnt >= NEST)) |=>
         fault_o && (fault_cause_o == 2'd1) && $stable(active_stack_o));

   p_iret_unf_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (ev_iret && (nest_cnt == 0)) |=>
         fault_o && (fault_cause_o == 2'd2) && $stable(active_stack_o));

   p_int_zero_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      (ev_int && (evt_level_i == '0)) |=> !fault_o && $stable(active_stack_o));

   p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (rst_i)
      !evt_valid_i |=> !fault_o && !ret_ok_o && !access_deny_o && $stable(active_stack_o));

   p_cause_legal_r11: assert property (@(posedge clk_i) disable iff (rst_i)
      fault_o |-> (fault_cause_o != 2'd3));

   p_cause_zero_r11: assert property (@(posedge clk_i) disable iff (rst_i)
      !fault_o |-> (fault_cause_o == 2'd0));

endmodule

bind shadow_ret_guard srs_guard_chk #(
   .SEL_W (SEL_W),
   .NEST  (NEST)
) u_chk (
   .clk_i          (clk_i),
   .rst_i          (rst_i),
   .evt_valid_i    (evt_valid_i),
   .evt_kind_i     (evt_kind_i),
   .evt_level_i    (evt_level_i),
   .ret_ok_o       (ret_ok_o),
   .fault_o        (fault_o),
   .fault_cause_o  (fault_cause_o),
   .access_deny_o  (access_deny_o),
   .active_stack_o (active_stack_o)
);

// File: tb/shadow_ret_guard_tb_top.sv
`timescale 1ns/1ps
module shadow_ret_guard_tb_top;

   localparam int AW    = 32;
   localparam int DEPTH = 16;
   localparam int NSTK  = 8;
   localparam int NEST  = 2;
   localparam int SW    = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          ev_valid = 1'b0;
   logic [2:0]    ev_kind = '0;
   logic [AW-1:0] ev_addr = '0;
   logic [SW-1:0] ev_lvl = '0;
   logic          ret_ok, fault, deny;
   logic [1:0]    cause;
   logic [SW-1:0] act;

   always #2.5 clk = ~clk;

   shadow_ret_guard dut_i (
      .clk_i          (clk),
      .rst_i          (rst),
      .evt_valid_i    (ev_valid),
      .evt_kind_i     (ev_kind),
      .evt_addr_i     (ev_addr),
      .evt_level_i    (ev_lvl),
      .ret_ok_o       (ret_ok),
      .fault_o        (fault),
      .fault_cause_o  (cause),
      .access_deny_o  (deny),
      .active_stack_o (act)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit timed_out = 1'b0;

   // reference model
   logic [AW-1:0] m_mem [NSTK][DEPTH];
   int            m_cnt [NSTK];
   int            m_nest [NEST];
   int            m_ncnt;
   int            m_sel;
   bit            e_fault, e_ok, e_deny;
   int            e_cause;

   task automatic model_reset();
      for (int i = 0; i < NSTK; i++) m_cnt[i] = 0;
      m_ncnt = 0; m_sel = 0;
      e_fault = 0; e_ok = 0; e_deny = 0; e_cause = 0;
   endtask

   task automatic model_step(input bit v, input int k, input logic [AW-1:0] a, input int l);
      e_fault = 0; e_ok = 0; e_deny = 0; e_cause = 0;
      if (v) begin
         case (k)
            0: if (m_cnt[m_sel] == DEPTH) begin e_fault = 1; e_cause = 1; end
               else begin m_mem[m_sel][m_cnt[m_sel]] = a; m_cnt[m_sel]++; end
            1: if (m_cnt[m_sel] == 0) begin e_fault = 1; e_cause = 2; end
               else begin
                  m_cnt[m_sel]--;
                  if (m_mem[m_sel][m_cnt[m_sel]] == a) e_ok = 1;
                  else begin e_fault = 1; e_cause = 0; end
               end
            2: if (l != 0) begin
                  if (m_ncnt == NEST) begin e_fault = 1; e_cause = 1; end
                  else begin m_nest[m_ncnt] = m_sel; m_ncnt++; m_sel = l; end
               end
            3: if (m_ncnt == 0) begin e_fault = 1; e_cause = 2; end
               else begin m_ncnt--; m_sel = m_nest[m_ncnt]; end
            4, 5: e_deny = 1;
            default: ;
         endcase
      end
   endtask

   task automatic check(input string tag);
      n_chk++;
      if (fault !== e_fault || ret_ok !== e_ok || deny !== e_deny ||
          (e_fault && cause !== e_cause[1:0]) || act !== m_sel[SW-1:0]) begin
         n_fail++;
         $display("FAIL %s: got fault=%0b cause=%0d ok=%0b deny=%0b sel=%0d, expected fault=%0b cause=%0d ok=%0b deny=%0b sel=%0d",
                  tag, fault, cause, ret_ok, deny, act, e_fault, e_cause, e_ok, e_deny, m_sel);
      end
   endtask

   // drive one event at a falling edge, check the registered result one cycle later
   task automatic ev(input bit v, input int k, input logic [AW-1:0] a, input int l, input string tag);
      ev_valid = v; ev_kind = 3'(k); ev_addr = a; ev_lvl = SW'(l);
      model_step(v, k, a, l);
      @(posedge clk);
      @(negedge clk);
      check(tag);
   endtask

   function automatic string tag_of(input int k);
      case (k)
         0: return "R2";
         1: return "R3";
         2: return "R7";
         3: return "R8";
         4, 5: return "R6";
         default: return "R11";
      endcase
   endfunction

   task automatic run_all();
      // R1: reset state
      model_reset();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset outputs");
      rst = 1'b0;
      ev(1, 1, 32'h1234_5678, 0, "R1 R5 return on empty after reset");
      ev(0, 0, 32'h0, 0, "R11 idle cycle quiet");
      // R2: LIFO matching
      ev(1, 0, 32'h1000_0010, 0, "R2 call A");
      ev(1, 0, 32'h1000_0020, 0, "R2 call B");
      ev(1, 1, 32'h1000_0020, 0, "R2 ret B match");
      ev(1, 1, 32'h1000_0010, 0, "R2 ret A match");
      // R3: mismatch consumes entry
      ev(1, 0, 32'h2000_0100, 0, "R3 call P");
      ev(1, 0, 32'h2000_0200, 0, "R3 call Q");
      ev(1, 1, 32'h6666_0000, 0, "R3 ret wrong address");
      ev(1, 1, 32'h2000_0100, 0, "R3 next ret sees P");
      // R4: overflow
      for (int i = 0; i < DEPTH; i++) ev(1, 0, 32'hA000_0000 + 32'(i * 4), 0, "R4 fill");
      ev(1, 0, 32'hDEAD_0000, 0, "R4 call on full");
      for (int i = DEPTH - 1; i >= 0; i--) ev(1, 1, 32'hA000_0000 + 32'(i * 4), 0, "R4 drain intact");
      ev(1, 1, 32'hDEAD_0000, 0, "R5 return on empty");
      // R6: loads and stores refused, no effect
      ev(1, 0, 32'h3000_0004, 0, "R6 call C");
      ev(1, 4, 32'h3000_0004, 0, "R6 load denied");
      ev(1, 5, 32'h9999_9999, 3, "R6 store denied");
      ev(1, 1, 32'h3000_0004, 0, "R6 ret C unaffected");
      // R7 R8 R9: stack switching and nesting
      ev(1, 0, 32'h4000_0000, 0, "R7 call on stack 0");
      ev(1, 2, 32'h0, 3, "R7 interrupt to stack 3");
      ev(1, 1, 32'h4000_0000, 0, "R7 stack 3 empty");
      ev(1, 0, 32'h4300_0000, 0, "R7 call on stack 3");
      ev(1, 2, 32'h0, 5, "R7 interrupt to stack 5");
      ev(1, 2, 32'h0, 6, "R9 third nesting refused");
      ev(1, 3, 32'h0, 0, "R8 return to stack 3");
      ev(1, 1, 32'h4300_0000, 0, "R7 stack 3 entry kept");
      ev(1, 3, 32'h0, 0, "R8 return to stack 0");
      ev(1, 3, 32'h0, 0, "R9 interrupt-return with no nesting");
      ev(1, 2, 32'h0, 0, "R10 level 0 ignored");
      ev(1, 1, 32'h4000_0000, 0, "R7 stack 0 entry kept");
      ev(1, 6, 32'h0, 0, "R11 unused kind quiet");
      ev(0, 1, 32'h0, 0, "R11 invalid event quiet");
      // random phase
      void'($urandom(32'd20240611));
      for (int n = 0; n < 4000; n++) begin
         int unsigned r;
         int k;
         logic [AW-1:0] a;
         bit v;
         r = $urandom % 100;
         v = 1'b1;
         if (r < 35) k = 0;
         else if (r < 70) k = 1;
         else if (r < 78) k = 2;
         else if (r < 86) k = 3;
         else if (r < 92) k = 4 + int'($urandom % 2);
         else begin k = 6 + int'($urandom % 2); v = ($urandom % 2) == 0; end
         a = $urandom;
         if (k == 1 && m_cnt[m_sel] > 0 && ($urandom % 4) != 0) a = m_mem[m_sel][m_cnt[m_sel] - 1];
         ev(v, k, a, int'($urandom % 8), tag_of(k));
      end
      ev_valid = 1'b0;
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got run still busy, expected completion");
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule